// File: doc/BRIEF.md
# Return-Address Stack

This block keeps the return addresses of a small processor core. The core pushes the full program counter when it takes a call or enters an interrupt. It pops that value back on a return. The top entry is always visible on a combinational output, so a return gets its target in the same cycle as the pop strobe. The returned value is the whole program counter as it was pushed, so no page or bank bits have to be merged back in afterwards.

Parameters set the stack depth (2, 8, 16 and 31 entries are all supported, as is any other depth of one or more), the program-counter width and the pointer policy. In circular mode the pointer wraps around with no error detection, and the oldest entries are overwritten. In bounded mode the pointer stops at its limits. A push onto a full stack or a pop from an empty one is refused, sets a sticky error flag and asks the reset generator for a reset, instead of corrupting entries silently. An optional register port lets software read and write the top entry and the stack pointer, and clear the sticky flags.

Top module: `retstk`

## Requirements
- R1: A push stores `push_pc_i` above the current top and raises `sp_o` by one. From the next cycle `pc_o` shows that value. Successive pops return the pushed values in reverse order, for any `DEPTH`.
- R2: `pc_o` is combinational from the stored state, so in the cycle of a pop it already carries the entry being popped. It carries all `PC_W` bits exactly as pushed (for example 15'h7FFF comes back unchanged).
- R3: In circular mode (`BOUNDED`=0), `sp_o` runs from 0 to `DEPTH`-1. A push at `DEPTH`-1 wraps it to 0 and overwrites the oldest entry. A pop at 0 wraps it to `DEPTH`-1. No flag and no reset request is ever raised.
- R4: In bounded mode, a push without a pop while `sp_o`==`DEPTH` leaves the entries and `sp_o` unchanged. From the next cycle `ovf_o` is set, and `rst_req_o` is high for exactly that one next cycle.
- R5: In bounded mode, a pop while `sp_o`==0 drives `pc_o` to all zeros in that cycle and leaves `sp_o` at 0. From the next cycle `unf_o` is set, and `rst_req_o` is high for exactly that one cycle. A push and pop together on an empty stack count as an underflow and store nothing.
- R6: A push and a pop in the same cycle on a non-empty stack replace the top entry with `push_pc_i` and leave `sp_o` unchanged.
- R7: `ovf_o` and `unf_o` stay set until reset or until a cycle with `flag_clr_i`=1. If a new error occurs in the same cycle as the clear, the flag stays set.
- R8: `sw_rdata_o` returns the top entry (the value on `pc_o`) when `sw_sel_i`=0. It returns `sp_o` zero-extended to `PC_W` bits when `sw_sel_i`=1.
- R9: In a cycle with no push and no pop, `sw_wr_i` with `sw_sel_i`=0 overwrites the top entry. This write is ignored in bounded mode when the stack is empty. `sw_wr_i` with `sw_sel_i`=1 loads `sp_o` from `sw_wdata_i` if the value is at most `DEPTH` (bounded) or below `DEPTH` (circular), and is ignored otherwise. Any software write in a cycle with a push or a pop is ignored.
- R10: In bounded mode `full_o` is 1 exactly when `sp_o`==`DEPTH` and `empty_o` is 1 exactly when `sp_o`==0. In circular mode both are always 0.
- R11: After reset, `sp_o` is 0, all entries are zero, and `ovf_o`, `unf_o` and `rst_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| pop_i | input | 1 | Pop strobe (return) |
| push_pc_i | input | PC_W | Address to push |
| pc_o | output | PC_W | Current top entry, return target |
| sp_o | output | $clog2(DEPTH+1) | Stack pointer (entry count in bounded mode) |
| full_o | output | 1 | Stack full (bounded mode only) |
| empty_o | output | 1 | Stack empty (bounded mode only) |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle reset request after a bounded-mode error |
| flag_clr_i | input | 1 | Clears the sticky flags |
| sw_wr_i | input | 1 | Software write strobe |
| sw_sel_i | input | 1 | Software target: 0 top entry, 1 pointer |
| sw_wdata_i | input | PC_W | Software write data |
| sw_rdata_o | output | PC_W | Software read data |

## Verification
`pc_o` and `sw_rdata_o` are combinational. They are due in the same cycle as the stimulus, so the bench samples them a short time after driving its inputs on the falling edge and before the rising edge that acts on them. The pointer, the stored entries, `full_o`, `empty_o`, the sticky flags and `rst_req_o` all change on the first rising edge after the strobe. The bench checks them on the falling edge that follows that rising edge. It checks `rst_req_o` on one further falling edge as well, to confirm the request lasts a single cycle.

// File: rtl/retstk_pkg.sv
// Shared types for the return-address stack.
// Assumes: the stack operation is encoded as {push, pop}.
package retstk_pkg;

    // Stack operation taken from the push/pop strobe pair.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_SWAP = 2'b11
    } stk_op_e;

    // Target of the software register port.
    typedef enum logic {
        SW_SEL_TOS = 1'b0,
        SW_SEL_PTR = 1'b1
    } sw_sel_e;

endpackage

// File: rtl/retstk_mem.sv
// Storage for the return-address stack: DEPTH registers of PC_W bits.
// It has one write port and one combinational read port.
// Assumes: write and read indices come from the pointer unit. A read index
// at or above DEPTH returns zero.
module retstk_mem #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 15,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [PC_W-1:0]  wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [PC_W-1:0]  rd_data_o
);

    logic [PC_W-1:0] slot_q [DEPTH];

    // Clear every slot on reset, otherwise write the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                slot_q[k] <= '0;
            end
        end else if (wr_en_i) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (wr_idx_i == IDX_W'(k)) begin
                    slot_q[k] <= wr_data_i;
                end
            end
        end
    end

    // Select the slot named by the read index, zero if out of range.
    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_idx_i == IDX_W'(k)) begin
                rd_data_o = slot_q[k];
            end
        end
    end

    // R1: a written slot holds the written value one cycle later
    assert_slot_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(wr_idx_i) < DEPTH) |=> slot_q[$past(wr_idx_i)] == $past(wr_data_i));

endmodule

// File: rtl/retstk_ptr.sv
// Pointer unit of the return-address stack. It decodes push/pop strobes and
// software writes into a slot write and a new pointer value. It also keeps
// the sticky error flags and the reset request.
// Assumes: software pointer values arrive already range-checked, and only
// one software write is requested per cycle.
module retstk_ptr
    import retstk_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter bit BOUNDED = 1'b1,
    parameter int PTR_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             sw_sp_we_i,
    input  logic [PTR_W-1:0] sw_sp_val_i,
    input  logic             sw_tos_we_i,
    input  logic             flag_clr_i,
    output logic [PTR_W-1:0] sp_o,
    output logic [PTR_W-1:0] top_idx_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic             wr_from_sw_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             rst_req_o
);

    logic [PTR_W-1:0] sp_q, sp_nxt;
    logic             ovf_q, unf_q, req_q;
    logic             ovf_evt, unf_evt;
    stk_op_e          op;

    assign op = stk_op_e'({push_i, pop_i});

    generate
        if (BOUNDED) begin : g_bounded
            localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH);

            // Decode the next pointer and slot write; refuse moves past the limits.
            always_comb begin
                sp_nxt       = sp_q;
                wr_en_o      = 1'b0;
                wr_idx_o     = sp_q;
                wr_from_sw_o = 1'b0;
                ovf_evt      = 1'b0;
                unf_evt      = 1'b0;
                full_o       = (sp_q == CAP);
                empty_o      = (sp_q == '0);
                top_idx_o    = sp_q - 1'b1;
                unique case (op)
                    OP_PUSH: begin
                        if (full_o) begin
                            ovf_evt = 1'b1;
                        end else begin
                            wr_en_o = 1'b1;
                            sp_nxt  = sp_q + 1'b1;
                        end
                    end
                    OP_POP: begin
                        if (empty_o) unf_evt = 1'b1;
                        else         sp_nxt  = sp_q - 1'b1;
                    end
                    OP_SWAP: begin
                        if (empty_o) begin
                            unf_evt = 1'b1;
                        end else begin
                            wr_en_o  = 1'b1;
                            wr_idx_o = sp_q - 1'b1;
                        end
                    end
                    default: begin
                        if (sw_sp_we_i) begin
                            sp_nxt = sw_sp_val_i;
                        end else if (sw_tos_we_i && !empty_o) begin
                            wr_en_o      = 1'b1;
                            wr_idx_o     = sp_q - 1'b1;
                            wr_from_sw_o = 1'b1;
                        end
                    end
                endcase
            end

            // R4: a push at the limit keeps the pointer and raises the error
            assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (push_i && !pop_i && sp_q == CAP) |=> (ovf_q && req_q && sp_q == CAP));
            // R5: a pop on an empty stack keeps the pointer and raises the error
            assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (pop_i && sp_q == '0) |=> (unf_q && req_q && sp_q == '0));
            // R1: a plain push below the limit grows the stack by one
            assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (push_i && !pop_i && sp_q != CAP) |=> sp_q == $past(sp_q) + 1'b1);
            // R7: flags stay set while no clear is requested
            assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (ovf_q && !flag_clr_i) |=> ovf_q);
            assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (unf_q && !flag_clr_i) |=> unf_q);
        end else begin : g_circular
            localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
            logic [PTR_W-1:0] sp_inc, sp_dec;

            // Wrap the pointer in both directions with no error detection.
            always_comb begin
                sp_inc       = (sp_q == LAST) ? '0 : sp_q + 1'b1;
                sp_dec       = (sp_q == '0) ? LAST : sp_q - 1'b1;
                sp_nxt       = sp_q;
                wr_en_o      = 1'b0;
                wr_idx_o     = sp_q;
                wr_from_sw_o = 1'b0;
                ovf_evt      = 1'b0;
                unf_evt      = 1'b0;
                full_o       = 1'b0;
                empty_o      = 1'b0;
                top_idx_o    = sp_dec;
                unique case (op)
                    OP_PUSH: begin
                        wr_en_o = 1'b1;
                        sp_nxt  = sp_inc;
                    end
                    OP_POP: begin
                        sp_nxt = sp_dec;
                    end
                    OP_SWAP: begin
                        wr_en_o  = 1'b1;
                        wr_idx_o = sp_dec;
                    end
                    default: begin
                        if (sw_sp_we_i) begin
                            sp_nxt = sw_sp_val_i;
                        end else if (sw_tos_we_i) begin
                            wr_en_o      = 1'b1;
                            wr_idx_o     = sp_dec;
                            wr_from_sw_o = 1'b1;
                        end
                    end
                endcase
            end

            // R3: a push at the last slot wraps to slot zero
            assert_wrap_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (push_i && !pop_i && sp_q == LAST) |=> sp_q == '0);
            // R3: a pop at slot zero wraps to the last slot
            assert_wrap_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (pop_i && !push_i && sp_q == '0) |=> sp_q == LAST);
            // R3: the pointer never leaves its range
            assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
                push_i |=> sp_q <= LAST);
        end
    endgenerate

    // Register the pointer, the sticky flags and the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            sp_q  <= sp_nxt;
            ovf_q <= ovf_evt | (ovf_q & ~flag_clr_i);
            unf_q <= unf_evt | (unf_q & ~flag_clr_i);
            req_q <= ovf_evt | unf_evt;
        end
    end

    assign sp_o      = sp_q;
    assign ovf_o     = ovf_q;
    assign unf_o     = unf_q;
    assign rst_req_o = req_q;

    // R6: push and pop together never move the pointer
    assert_swap_keeps_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> sp_q == $past(sp_q));
    // R4: the reset request never lasts two cycles in a row without a new error
    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !push_i && !pop_i) |=> !req_q);

endmodule

// File: rtl/retstk.sv
// Return-address stack top. It joins the pointer unit and the slot storage,
// masks the returned address on an empty bounded stack, and adds the
// optional software register port.
// Assumes: PC_W is at least the pointer width, so the pointer fits in a
// software read word.
module retstk
    import retstk_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int PC_W      = 15,
    parameter bit BOUNDED   = 1'b1,
    parameter bit SW_ACCESS = 1'b1,
    localparam int PTR_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [PC_W-1:0]  push_pc_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [PTR_W-1:0] sp_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             rst_req_o,
    input  logic             flag_clr_i,
    input  logic             sw_wr_i,
    input  logic             sw_sel_i,
    input  logic [PC_W-1:0]  sw_wdata_i,
    output logic [PC_W-1:0]  sw_rdata_o
);

    localparam int SP_LIMIT = BOUNDED ? DEPTH : DEPTH - 1;

    logic             sw_sp_we, sw_tos_we;
    logic [PTR_W-1:0] top_idx, wr_idx;
    logic             wr_en, wr_from_sw;
    logic [PC_W-1:0]  wr_data, rd_data;

    generate
        if (SW_ACCESS) begin : g_sw
            // Decode software writes; drop pointer values out of range.
            always_comb begin
                sw_sp_we  = sw_wr_i && (sw_sel_e'(sw_sel_i) == SW_SEL_PTR)
                            && (int'(sw_wdata_i) <= SP_LIMIT);
                sw_tos_we = sw_wr_i && (sw_sel_e'(sw_sel_i) == SW_SEL_TOS);
            end
            // Return the top entry or the zero-extended pointer.
            always_comb begin
                if (sw_sel_e'(sw_sel_i) == SW_SEL_PTR) sw_rdata_o = PC_W'(sp_o);
                else                                   sw_rdata_o = pc_o;
            end
        end else begin : g_no_sw
            // Without the port, software strobes are ignored and reads give zero.
            always_comb begin
                sw_sp_we   = 1'b0;
                sw_tos_we  = 1'b0;
                sw_rdata_o = '0;
            end
        end
    endgenerate

    retstk_ptr #(
        .DEPTH   (DEPTH),
        .BOUNDED (BOUNDED),
        .PTR_W   (PTR_W)
    ) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push_i),
        .pop_i        (pop_i),
        .sw_sp_we_i   (sw_sp_we),
        .sw_sp_val_i  (sw_wdata_i[PTR_W-1:0]),
        .sw_tos_we_i  (sw_tos_we),
        .flag_clr_i   (flag_clr_i),
        .sp_o         (sp_o),
        .top_idx_o    (top_idx),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .wr_from_sw_o (wr_from_sw),
        .full_o       (full_o),
        .empty_o      (empty_o),
        .ovf_o        (ovf_o),
        .unf_o        (unf_o),
        .rst_req_o    (rst_req_o)
    );

    // Pick the slot write data: software word or pushed address.
    always_comb begin
        wr_data = wr_from_sw ? sw_wdata_i : push_pc_i;
    end

    retstk_mem #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W),
        .IDX_W (PTR_W)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (top_idx),
        .rd_data_o (rd_data)
    );

    // Return target: zero on an empty bounded stack, else the top slot.
    always_comb begin
        pc_o = (BOUNDED && empty_o) ? '0 : rd_data;
    end

    // R10: full and empty are never both set
    assert_full_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));
    // R6: a swap on a non-empty stack shows the new address next cycle
    assert_swap_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o) |=> pc_o == $past(push_pc_i));

endmodule

// File: tb/retstk_bench.sv
// Directed bench: a bounded 8-entry stack (u_retstk) and a circular
// 31-entry stack (u_retstk_wrap), each checked against a bench model.
module retstk_bench;

    localparam int PW = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // bounded instance signals
    logic          a_push = 0, a_pop = 0, a_clr = 0, a_swwr = 0, a_sel = 0;
    logic [PW-1:0] a_pc = '0, a_wd = '0;
    logic [PW-1:0] a_pco, a_rd;
    logic [3:0]    a_sp;
    logic          a_full, a_empty, a_ovf, a_unf, a_req;
    logic [PW-1:0] a_pre, a_rd_pre;

    // circular instance signals
    logic          b_push = 0, b_pop = 0, b_clr = 0, b_swwr = 0, b_sel = 0;
    logic [PW-1:0] b_pc = '0, b_wd = '0;
    logic [PW-1:0] b_pco, b_rd;
    logic [5:0]    b_sp;
    logic          b_full, b_empty, b_ovf, b_unf, b_req;
    logic [PW-1:0] b_pre;

    retstk #(.DEPTH(8), .PC_W(PW), .BOUNDED(1'b1), .SW_ACCESS(1'b1)) u_retstk (
        .clk(clk), .rst_n(rst_n), .push_i(a_push), .pop_i(a_pop), .push_pc_i(a_pc),
        .pc_o(a_pco), .sp_o(a_sp), .full_o(a_full), .empty_o(a_empty),
        .ovf_o(a_ovf), .unf_o(a_unf), .rst_req_o(a_req), .flag_clr_i(a_clr),
        .sw_wr_i(a_swwr), .sw_sel_i(a_sel), .sw_wdata_i(a_wd), .sw_rdata_o(a_rd));

    retstk #(.DEPTH(31), .PC_W(PW), .BOUNDED(1'b0), .SW_ACCESS(1'b1)) u_retstk_wrap (
        .clk(clk), .rst_n(rst_n), .push_i(b_push), .pop_i(b_pop), .push_pc_i(b_pc),
        .pc_o(b_pco), .sp_o(b_sp), .full_o(b_full), .empty_o(b_empty),
        .ovf_o(b_ovf), .unf_o(b_unf), .rst_req_o(b_req), .flag_clr_i(b_clr),
        .sw_wr_i(b_swwr), .sw_sel_i(b_sel), .sw_wdata_i(b_wd), .sw_rdata_o(b_rd));

    logic [PW-1:0] qa [$];       // bounded model
    logic [PW-1:0] bm [31];      // circular model
    int            bsp = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle on the bounded stack; called on a falling edge, returns on the next.
    task automatic a_cyc(input logic push, input logic pop, input logic [PW-1:0] pc,
                         input logic swwr, input logic sel, input logic [PW-1:0] wd,
                         input logic clr);
        a_push = push; a_pop = pop; a_pc = pc; a_swwr = swwr; a_sel = sel; a_wd = wd; a_clr = clr;
        #2;
        a_pre = a_pco; a_rd_pre = a_rd;
        @(negedge clk);
        a_push = 0; a_pop = 0; a_swwr = 0; a_sel = 0; a_clr = 0;
    endtask

    task automatic b_cyc(input logic push, input logic pop, input logic [PW-1:0] pc,
                         input logic swwr, input logic sel, input logic [PW-1:0] wd);
        b_push = push; b_pop = pop; b_pc = pc; b_swwr = swwr; b_sel = sel; b_wd = wd;
        #2;
        b_pre = b_pco;
        @(negedge clk);
        b_push = 0; b_pop = 0; b_swwr = 0; b_sel = 0;
    endtask

    task automatic t_reset();
        chk("R11 sp", a_sp, 0);
        chk("R11 ovf", a_ovf, 0);
        chk("R11 unf", a_unf, 0);
        chk("R11 req", a_req, 0);
        chk("R10 empty after reset", a_empty, 1);
        chk("R10 full after reset", a_full, 0);
        chk("R11 wrap sp", b_sp, 0);
        chk("R11 wrap entry zero", b_pco, 0);
        chk("R10 circular empty", b_empty, 0);
    endtask

    task automatic t_lifo();
        for (int i = 0; i < 8; i++) begin
            logic [PW-1:0] v;
            v = (i == 0) ? 15'h7FFF : PW'(15'h2000 + i * 15'h0123);
            a_cyc(1, 0, v, 0, 0, 0, 0);
            qa.push_back(v);
            chk("R1 sp after push", a_sp, i + 1);
            chk("R1 top after push", a_pco, v);
        end
        chk("R10 full at depth", a_full, 1);
        for (int i = 0; i < 8; i++) begin
            logic [PW-1:0] e;
            e = qa.pop_back();
            a_cyc(0, 1, 0, 0, 0, 0, 0);
            chk("R2 pop value same cycle", a_pre, e);
        end
        chk("R10 empty after drain", a_empty, 1);
        chk("R1 sp after drain", a_sp, 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 8; i++) begin
            a_cyc(1, 0, PW'(15'h0300 + i), 0, 0, 0, 0);
            qa.push_back(PW'(15'h0300 + i));
        end
        a_cyc(1, 0, 15'h1234, 0, 0, 0, 0);
        chk("R4 ovf set", a_ovf, 1);
        chk("R4 req pulse", a_req, 1);
        chk("R4 sp held", a_sp, 8);
        chk("R4 top unchanged", a_pco, 15'h0307);
        a_cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R4 req one cycle", a_req, 0);
        chk("R7 ovf sticky", a_ovf, 1);
        for (int i = 0; i < 8; i++) begin
            logic [PW-1:0] e;
            e = qa.pop_back();
            a_cyc(0, 1, 0, 0, 0, 0, 0);
            chk("R4 entries kept", a_pre, e);
        end
        a_cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R7 clear ovf", a_ovf, 0);
    endtask

    task automatic t_underflow();
        a_cyc(0, 1, 0, 0, 0, 0, 0);
        chk("R5 empty pop returns zero", a_pre, 0);
        chk("R5 unf set", a_unf, 1);
        chk("R5 req pulse", a_req, 1);
        chk("R5 sp held", a_sp, 0);
        a_cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R5 req one cycle", a_req, 0);
        a_cyc(1, 1, 15'h0555, 0, 0, 0, 1);
        chk("R5 swap on empty stores nothing", a_sp, 0);
        chk("R5 swap on empty is underflow", a_req, 1);
        chk("R7 error beats clear", a_unf, 1);
        a_cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R7 unf sticky", a_unf, 1);
        chk("R7 ovf untouched", a_ovf, 0);
        a_cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R7 clear unf", a_unf, 0);
    endtask

    task automatic t_swap();
        a_cyc(1, 0, 15'h0111, 0, 0, 0, 0);
        a_cyc(1, 0, 15'h0222, 0, 0, 0, 0);
        a_cyc(1, 1, 15'h0333, 0, 0, 0, 0);
        chk("R6 swap returns old top", a_pre, 15'h0222);
        chk("R6 swap keeps sp", a_sp, 2);
        chk("R6 swap new top", a_pco, 15'h0333);
        a_cyc(0, 1, 0, 0, 0, 0, 0);
        chk("R6 pop replaced", a_pre, 15'h0333);
        a_cyc(0, 1, 0, 0, 0, 0, 0);
        chk("R6 lower entry kept", a_pre, 15'h0111);
    endtask

    task automatic t_sw();
        a_cyc(1, 0, 15'h00AA, 0, 0, 0, 0);
        a_cyc(1, 0, 15'h00BB, 0, 0, 0, 0);
        a_cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R8 read pointer", a_rd_pre, 2);
        a_cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R8 read top", a_rd_pre, 15'h00BB);
        a_cyc(0, 0, 0, 1, 0, 15'h05A5, 0);
        chk("R9 write top", a_pco, 15'h05A5);
        chk("R9 write top keeps sp", a_sp, 2);
        a_cyc(0, 0, 0, 1, 1, 15'd9, 0);
        chk("R9 out-of-range sp ignored", a_sp, 2);
        a_cyc(0, 0, 0, 1, 1, 15'd1, 0);
        chk("R9 sp write", a_sp, 1);
        chk("R9 top follows sp", a_pco, 15'h00AA);
        a_cyc(1, 0, 15'h00CC, 1, 1, 15'd5, 0);
        chk("R9 sw ignored during push", a_sp, 2);
        chk("R9 push wins", a_pco, 15'h00CC);
        a_cyc(0, 0, 0, 1, 1, 15'd0, 0);
        a_cyc(0, 0, 0, 1, 0, 15'h0777, 0);
        a_cyc(0, 0, 0, 1, 1, 15'd1, 0);
        chk("R9 top write on empty ignored", a_pco, 15'h00AA);
        a_cyc(0, 0, 0, 1, 1, 15'd0, 0);
    endtask

    task automatic t_wrap();
        for (int k = 0; k < 31; k++) bm[k] = '0;
        bsp = 0;
        for (int i = 0; i < 33; i++) begin
            logic [PW-1:0] v;
            v = PW'(15'h0100 + i);
            b_cyc(1, 0, v, 0, 0, 0);
            bm[bsp] = v;
            bsp = (bsp + 1) % 31;
            if (b_req || b_ovf || b_full) chk("R3 no error on push", {b_req, b_ovf, b_full}, 0);
        end
        chk("R3 sp wrapped", b_sp, 2);
        chk("R3 newest on top", b_pco, 15'h0120);
        for (int i = 0; i < 33; i++) begin
            bsp = (bsp + 30) % 31;
            b_cyc(0, 1, 0, 0, 0, 0);
            chk("R3 wrap pop value", b_pre, bm[bsp]);
            if (b_req || b_unf || b_empty) chk("R3 no error on pop", {b_req, b_unf, b_empty}, 0);
        end
        chk("R3 sp after wrap pops", b_sp, bsp);
        b_cyc(0, 0, 0, 1, 1, 15'd31);
        chk("R9 circular sp limit", b_sp, bsp);
        b_cyc(0, 0, 0, 1, 1, 15'd30);
        chk("R9 circular sp write", b_sp, 30);
        chk("R9 circular top", b_pco, bm[29]);
        chk("R3 flags never set", {b_ovf, b_unf, b_req}, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lifo();
        t_overflow();
        t_underflow();
        t_swap();
        t_sw();
        t_wrap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule